// File: doc/BRIEF.md
# Boot-Block Protect and Erase Gate

This block sits between a flash command decoder and the erase/program engine. Each request carries a kind, a 20-bit word address, the level of the active-low write-protect pin and a strap that selects whether the small boot region sits at the bottom or at the top of the address space. The gate decides whether the operation may go ahead. For an accepted request, it gives the base word address and the word count of the region that the engine must touch.

The address space is split into 32-KWord blocks. The one 32-KWord span at the boot end is split further into an 8-KWord boot block, two 4-KWord blocks and one 16-KWord block. Counted from the boot end, these come in that order. The top-boot layout is the exact mirror of the bottom-boot layout. A low write-protect pin locks the 8-KWord boot block against every kind of change, and it also refuses whole-array erase. A refused request is dropped. Only a reject pulse marks it, and it leaves the region outputs as they were.

The decision and the region are registered. Both appear one clock after the request cycle. The write-protect level and the boot strap are taken from the request cycle itself.

Top module: `boot_protect_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, accept and reject are 0, region_base is 0 and region_words is 0.
- R2: A request (req_valid=1) produces exactly one single-cycle pulse on accept or on reject, in the next cycle. No pulse occurs in a cycle that follows a cycle without a request.
- R3: An accepted word program (req_kind=0) gives region_base = req_addr and region_words = 1.
- R4: An accepted sector erase (req_kind=1) gives region_base = req_addr with bits 10..0 cleared, and region_words = 2048.
- R5: An accepted block erase (req_kind=2) outside the 32-KWord boot-end span gives region_base = req_addr with bits 14..0 cleared, and region_words = 32768.
- R6: With cfg_top_boot=0, a block erase inside 00000h-07FFFh maps as follows: 00000h-01FFFh gives base 00000h with 8192 words; 02000h-02FFFh gives 02000h with 4096; 03000h-03FFFh gives 03000h with 4096; 04000h-07FFFh gives 04000h with 16384.
- R7: With cfg_top_boot=1, a block erase inside F8000h-FFFFFh maps as follows: FE000h-FFFFFh gives FE000h with 8192 words; FD000h-FDFFFh gives FD000h with 4096; FC000h-FCFFFh gives FC000h with 4096; F8000h-FBFFFh gives F8000h with 16384. In this mode, 00000h-07FFFh is an ordinary 32-KWord block.
- R8: An accepted chip erase (req_kind=3) gives region_base = 0 and region_words = 1048576.
- R9: With wp_n=0, a program, sector erase or block erase is rejected if its address falls in the boot block. The boot block is 00000h-01FFFh for bottom boot and FE000h-FFFFFh for top boot. The same kinds are accepted at any other address.
- R10: With wp_n=0, every chip erase is rejected.
- R11: With wp_n=1, every request is accepted, including those that target the boot block.
- R12: region_base and region_words change only in a cycle where accept is 1. A rejected request leaves both unchanged.
- R13: The decision uses the wp_n level of the request cycle. A change of wp_n in the following cycle does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_top_boot | input | 1 | 1: boot region at the top of the address space; 0: at the bottom |
| wp_n | input | 1 | Write-protect pin level; 0 locks the boot block and chip erase |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 20 | Word address of the request |
| accept | output | 1 | One-cycle pulse: request allowed |
| reject | output | 1 | One-cycle pulse: request dropped |
| region_base | output | 20 | Base word address of the last accepted region |
| region_words | output | 21 | Word count of the last accepted region |

## Verification
The assertions assume that wp_n and cfg_top_boot are already settled in the cycle where req_valid is high. The pin is expected to be driven and never left floating. The stimulus sets both inputs together with each request, in the same step. In the one sequence that moves wp_n on the very next cycle, it does so on purpose, to show that the earlier decision stands. The assertions also treat a request in every cycle as legal, and the stimulus issues back-to-back requests to match.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM     = 2'd0,
    OP_SECTOR_ERASE = 2'd1,
    OP_BLOCK_ERASE = 2'd2,
    OP_CHIP_ERASE  = 2'd3
  } op_kind_e;

endpackage

// File: rtl/bpg_block_map.sv
module bpg_block_map #(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 15,
  parameter int BOOT_W  = 13,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int HI_W   = ADDR_W - BOOT_W
) (
  input  logic              top_boot,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] blk_base,
  output logic [CNT_W-1:0]  blk_words
);

  localparam int SPLIT = BLOCK_W - BOOT_W;
  localparam logic [CNT_W-1:0] SZ_BIG   = CNT_W'(1) << BLOCK_W;
  localparam logic [CNT_W-1:0] SZ_BOOT  = CNT_W'(1) << BOOT_W;
  localparam logic [CNT_W-1:0] SZ_SMALL = CNT_W'(1) << (BOOT_W - 1);
  localparam logic [CNT_W-1:0] SZ_MID   = CNT_W'(1) << (BOOT_W + 1);
  localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);

  logic [HI_W-1:0]   hi_m;
  logic              in_boot_span;
  logic [ADDR_W-1:0] size_mask;

  // Mirror the address for top boot so one layout table serves both ends.
  assign hi_m         = top_boot ? ~addr[ADDR_W-1:BOOT_W] : addr[ADDR_W-1:BOOT_W];
  assign in_boot_span = (hi_m[HI_W-1:SPLIT] == '0);

  always_comb begin
    if (!in_boot_span) begin
      blk_words = SZ_BIG;
    end else begin
      case (hi_m[SPLIT-1:0])
        2'd0:    blk_words = SZ_BOOT;
        2'd1:    blk_words = SZ_SMALL;
        default: blk_words = SZ_MID;
      endcase
    end
  end

  // Every block is aligned to its size at either end, so clearing the
  // offset bits of the real address gives the base.
  assign size_mask = blk_words[ADDR_W-1:0] - ONE_A;
  assign blk_base  = addr & ~size_mask;

endmodule

// File: rtl/bpg_protect_eval.sv
module bpg_protect_eval
  import bpg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BOOT_W = 13,
  localparam int HI_W  = ADDR_W - BOOT_W
) (
  input  logic            top_boot,
  input  logic            wp_n,
  input  op_kind_e        kind,
  input  logic [HI_W-1:0] addr_hi,
  output logic            allow
);

  logic hits_boot;

  assign hits_boot = top_boot ? (&addr_hi) : (~|addr_hi);

  always_comb begin
    if (wp_n) begin
      allow = 1'b1;
    end else if (kind == OP_CHIP_ERASE) begin
      allow = 1'b0;
    end else begin
      allow = !hits_boot;
    end
  end

endmodule

// File: rtl/boot_protect_gate.sv
module boot_protect_gate
  import bpg_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SECTOR_W = 11,
  parameter int BLOCK_W  = 15,
  parameter int BOOT_W   = 13,
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_top_boot,
  input  logic              wp_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              accept,
  output logic              reject,
  output logic [ADDR_W-1:0] region_base,
  output logic [CNT_W-1:0]  region_words
);

  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECTOR_W) - 1);
  localparam logic [CNT_W-1:0]  SZ_SECT   = CNT_W'(1) << SECTOR_W;
  localparam logic [CNT_W-1:0]  SZ_CHIP   = CNT_W'(1) << ADDR_W;

  op_kind_e          kind;
  logic              allow;
  logic [ADDR_W-1:0] blk_base;
  logic [CNT_W-1:0]  blk_words;
  logic [ADDR_W-1:0] nxt_base;
  logic [CNT_W-1:0]  nxt_words;

  assign kind = op_kind_e'(req_kind);

  bpg_block_map #(
    .ADDR_W (ADDR_W),
    .BLOCK_W(BLOCK_W),
    .BOOT_W (BOOT_W)
  ) u_map (
    .top_boot (cfg_top_boot),
    .addr     (req_addr),
    .blk_base (blk_base),
    .blk_words(blk_words)
  );

  bpg_protect_eval #(
    .ADDR_W(ADDR_W),
    .BOOT_W(BOOT_W)
  ) u_prot (
    .top_boot(cfg_top_boot),
    .wp_n    (wp_n),
    .kind    (kind),
    .addr_hi (req_addr[ADDR_W-1:BOOT_W]),
    .allow   (allow)
  );

  always_comb begin
    case (kind)
      OP_PROGRAM: begin
        nxt_base  = req_addr;
        nxt_words = CNT_W'(1);
      end
      OP_SECTOR_ERASE: begin
        nxt_base  = req_addr & ~SECT_MASK;
        nxt_words = SZ_SECT;
      end
      OP_BLOCK_ERASE: begin
        nxt_base  = blk_base;
        nxt_words = blk_words;
      end
      default: begin
        nxt_base  = '0;
        nxt_words = SZ_CHIP;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept       <= 1'b0;
      reject       <= 1'b0;
      region_base  <= '0;
      region_words <= '0;
    end else begin
      accept <= req_valid && allow;
      reject <= req_valid && !allow;
      if (req_valid && allow) begin
        region_base  <= nxt_base;
        region_words <= nxt_words;
      end
    end
  end

endmodule

// File: rtl/bpg_gate_chk.sv
module bpg_gate_chk #(
  parameter int ADDR_W = 20,
  parameter int BOOT_W = 13,
  localparam int CNT_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_top_boot,
  input logic              wp_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic              accept,
  input logic              reject,
  input logic [ADDR_W-1:0] region_base,
  input logic [CNT_W-1:0]  region_words
);

  logic in_boot;
  assign in_boot = cfg_top_boot ? (&req_addr[ADDR_W-1:BOOT_W])
                                : (~|req_addr[ADDR_W-1:BOOT_W]);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (accept ^ reject));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!accept && !reject));

  assert_boot_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !wp_n && req_kind != 2'd3 && in_boot) |=> reject);

  assert_outside_open_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !wp_n && req_kind != 2'd3 && !in_boot) |=> accept);

  assert_chip_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !wp_n && req_kind == 2'd3) |=> reject);

  assert_pin_high_open_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && wp_n) |=> accept);

  assert_region_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !accept |-> ($stable(region_base) && $stable(region_words)));

  assert_region_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    accept |-> ($countones(region_words) == 1 &&
               (region_base & (region_words[ADDR_W-1:0] - ADDR_W'(1))) == '0));

endmodule

bind boot_protect_gate bpg_gate_chk #(
  .ADDR_W(ADDR_W),
  .BOOT_W(BOOT_W)
) u_chk (.*);

// File: tb/boot_protect_gate_test.sv
module boot_protect_gate_test;

  localparam int AW = 20;
  localparam int CW = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_top_boot = 1'b0;
  logic          wp_n = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          accept, reject;
  logic [AW-1:0] region_base;
  logic [CW-1:0] region_words;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  typedef struct {
    bit            acc;
    logic [AW-1:0] base;
    logic [CW-1:0] words;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  logic [AW-1:0] held_base = '0;
  logic [CW-1:0] held_words = '0;

  always #4 clk = ~clk;

  boot_protect_gate uut (
    .clk(clk), .rst(rst), .cfg_top_boot(cfg_top_boot), .wp_n(wp_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .accept(accept), .reject(reject),
    .region_base(region_base), .region_words(region_words)
  );

  // Expected region for a block erase, written as explicit address ranges.
  task automatic block_of(input logic [AW-1:0] a, input bit top,
                          output logic [AW-1:0] b, output logic [CW-1:0] w);
    if (!top && a < 20'h02000)      begin b = 20'h00000; w = 21'd8192;  end
    else if (!top && a < 20'h03000) begin b = 20'h02000; w = 21'd4096;  end
    else if (!top && a < 20'h04000) begin b = 20'h03000; w = 21'd4096;  end
    else if (!top && a < 20'h08000) begin b = 20'h04000; w = 21'd16384; end
    else if (top && a >= 20'hFE000) begin b = 20'hFE000; w = 21'd8192;  end
    else if (top && a >= 20'hFD000) begin b = 20'hFD000; w = 21'd4096;  end
    else if (top && a >= 20'hFC000) begin b = 20'hFC000; w = 21'd4096;  end
    else if (top && a >= 20'hF8000) begin b = 20'hF8000; w = 21'd16384; end
    else begin b = {a[19:15], 15'h0}; w = 21'd32768; end
  endtask

  task automatic send(input logic [1:0] k, input logic [AW-1:0] a,
                      input bit wp, input bit top, input string tag);
    exp_t e;
    bit   prot;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; wp_n = wp; cfg_top_boot = top;
    prot = top ? (a >= 20'hFE000) : (a < 20'h02000);
    e.acc = wp || (k != 2'd3 && !prot);
    if (e.acc) begin
      case (k)
        2'd0: begin held_base = a; held_words = 21'd1; end
        2'd1: begin held_base = {a[19:11], 11'h0}; held_words = 21'd2048; end
        2'd2: block_of(a, top, held_base, held_words);
        default: begin held_base = '0; held_words = 21'd1048576; end
      endcase
    end
    e.base = held_base; e.words = held_words; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: one expected item is due at the first edge after it is pushed.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          n_checks++;
          if (accept !== e.acc || reject !== !e.acc ||
              region_base !== e.base || region_words !== e.words) begin
            n_fail++;
            $display("FAIL %s: acc=%0b rej=%0b base=%h words=%0d expected acc=%0b rej=%0b base=%h words=%0d",
                     e.tag, accept, reject, region_base, region_words,
                     e.acc, !e.acc, e.base, e.words);
          end
        end else if (accept || reject) begin
          n_checks++;
          n_fail++;
          $display("FAIL R2: acc=%0b rej=%0b without request expected acc=0 rej=0",
                   accept, reject);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_checks++;
    if (accept !== 1'b0 || reject !== 1'b0 || region_base !== '0 || region_words !== '0) begin
      n_fail++;
      $display("FAIL R1: acc=%0b rej=%0b base=%h words=%0d expected 0 0 0 0",
               accept, reject, region_base, region_words);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    n_checks++;
    if (accept !== 1'b0 || reject !== 1'b0 || region_base !== '0 || region_words !== '0) begin
      n_fail++;
      $display("FAIL R1: after release acc=%0b rej=%0b base=%h words=%0d expected 0 0 0 0",
               accept, reject, region_base, region_words);
    end

    // Unprotected main function, bottom boot, back to back.
    send(2'd0, 20'h12345, 1'b1, 1'b0, "R3 program");
    send(2'd1, 20'h12FFF, 1'b1, 1'b0, "R4 sector");
    send(2'd2, 20'h5ABCD, 1'b1, 1'b0, "R5 big block");
    idle();
    send(2'd2, 20'h01000, 1'b1, 1'b0, "R6 R11 boot block open");
    send(2'd2, 20'h02800, 1'b1, 1'b0, "R6 first 4K");
    send(2'd2, 20'h03123, 1'b1, 1'b0, "R6 second 4K");
    send(2'd2, 20'h07FFF, 1'b1, 1'b0, "R6 16K");
    send(2'd2, 20'h08000, 1'b1, 1'b0, "R5 first big above span");
    idle();
    // Top boot mirror.
    send(2'd2, 20'hFFFFF, 1'b1, 1'b1, "R7 top boot block");
    send(2'd2, 20'hFD800, 1'b1, 1'b1, "R7 top upper 4K");
    send(2'd2, 20'hFC001, 1'b1, 1'b1, "R7 top lower 4K");
    send(2'd2, 20'hF9000, 1'b1, 1'b1, "R7 top 16K");
    send(2'd2, 20'h00100, 1'b1, 1'b1, "R7 bottom plain in top mode");
    send(2'd3, 20'h55555, 1'b1, 1'b0, "R8 chip erase open");
    idle();
    // Write protect low, bottom boot.
    send(2'd1, 20'h3A800, 1'b0, 1'b0, "R9 setup accept");
    send(2'd0, 20'h00010, 1'b0, 1'b0, "R9 R12 program boot rejected");
    send(2'd1, 20'h01FFF, 1'b0, 1'b0, "R9 R12 sector boot rejected");
    send(2'd1, 20'h02000, 1'b0, 1'b0, "R9 sector above boot");
    send(2'd2, 20'h01000, 1'b0, 1'b0, "R9 block boot rejected");
    send(2'd2, 20'h02000, 1'b0, 1'b0, "R9 block above boot");
    send(2'd3, 20'h00000, 1'b0, 1'b0, "R10 chip locked bottom");
    idle();
    // Write protect low, top boot.
    send(2'd0, 20'hFE000, 1'b0, 1'b1, "R9 top program boot rejected");
    send(2'd0, 20'h00010, 1'b0, 1'b1, "R9 top low address open");
    send(2'd2, 20'hFDFFF, 1'b0, 1'b1, "R9 top 4K below boot");
    send(2'd3, 20'hFFFFF, 1'b0, 1'b1, "R10 chip locked top");
    idle();
    // Pin change right after a protected request.
    send(2'd0, 20'h00020, 1'b0, 1'b0, "R13 sampled low");
    @(negedge clk);
    req_valid = 1'b0;
    wp_n = 1'b1;
    send(2'd0, 20'h00020, 1'b1, 1'b0, "R13 R11 sampled high");
    send(2'd0, 20'h00030, 1'b0, 1'b0, "R13 low again");
    idle();
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule